// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory

This block is the home-node directory of a small distributed shared memory system. For every line it owns, it keeps a coherence state, a clean/dirty flag, an overflow flag and a small fixed set of hardware sharer pointers. It also holds the line's data in a local array. Requests (read, write, write-back) arrive one at a time from the network interface over a valid/ready port. The controller answers with grant, share, forward and invalidate messages on a second valid/ready port, one message per handshake.

When a read would record more sharers than the pointers can hold, the controller still serves the read. It then marks the entry as overflowed and raises a trap line for a software handler. New requests to that line are stalled until software acknowledges the trap. A later write to an overflowed line invalidates the sharers the hardware knows about, grants the line, and traps again so that software can invalidate the sharers it recorded. Races between simultaneous writers are outside the block's scope: the controller simply serialises requests.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every line is unused, with no valid pointers, overflow clear and data zero. `req_ready` is 1 while `msg_valid` and `trap_valid` are 0.
- R2: A read (`req_kind` 00) of an unused line sends one grant (type 00) to the requester, carrying the line data. The line becomes exclusive and clean, with the requester as owner.
- R3: A read of an exclusive clean line by another node sends a share (type 01, data 0) to the owner, then a grant with the line data to the requester. The line becomes shared, with both nodes recorded.
- R4: A read of an exclusive dirty line by another node sends a single forward (type 10) to the owner, with the requester's id in the data field. No grant is sent and the entry is unchanged.
- R5: A write (`req_kind` 01) sends one invalidate (type 11, data 0) to each recorded sharer other than the writer, in ascending pointer-slot order, then a grant with the line data to the writer. The line then becomes exclusive and dirty, owned by the writer alone. A write to an unused line sends only the grant.
- R6: A write-back (`req_kind` 1x) stores `req_data` into the line and clears its dirty flag, sends no message, and leaves the state and pointers unchanged.
- R7: A read of a shared line by a new node when all pointers are in use is still granted. The entry's overflow bit is then set, and `trap_valid` rises with `trap_line`/`trap_node` naming the line and requester. The trap holds until `trap_ack`.
- R8: While a trap is pending, `req_ready` is 0 for requests to the trapped line and for any request that would raise a second trap. Other requests are accepted.
- R9: A write to an overflowed line performs R5, then raises the trap naming the line and writer, and clears the overflow bit.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the message fields stay stable. `req_ready` is 0 whenever a message is outstanding.
- R11: A read by a node already recorded for the line sends only a grant and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when both high |
| req_kind | input | 2 | 00 read, 01 write, 1x write-back |
| req_node | input | log2(NODES) | Requesting node id |
| req_line | input | log2(LINES) | Line index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_type | output | 2 | 00 grant, 01 share, 10 forward, 11 invalidate |
| msg_dest | output | log2(NODES) | Destination node |
| msg_line | output | log2(LINES) | Line index |
| msg_data | output | DATA_W | Line data (grant), requester id (forward), else 0 |
| trap_valid | output | 1 | Software trap pending |
| trap_line | output | log2(LINES) | Line that trapped |
| trap_node | output | log2(NODES) | Requester that caused the trap |
| trap_ack | input | 1 | Software acknowledge, clears the trap |

## Verification
The reads walk one line through every state. A first read of an unused line separates the exclusive grant from a plain shared grant. A second node reading a clean owner's line must produce share-then-grant, and the same read on a dirty line must produce only a forward. A repeat read by a recorded sharer shows that no pointer is duplicated. Filling all pointers and adding a fifth reader exercises the overflow trap and the per-line stall, while a request to an unrelated line proves the stall is local. The write on that full line is chosen so that slot order (nodes 2, 1, 7) differs from node-id order, and it runs under message backpressure to check field stability.

// File: rtl/dir_pkg.sv
// Shared encodings for the directory controller.
// Assumes: message and request codes are fixed by the network interface.
package dir_pkg;
    typedef enum logic [1:0] {
        ST_UNUSED = 2'b00,
        ST_SHARED = 2'b01,
        ST_EXCL   = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        MSG_GRANT = 2'b00,
        MSG_SHARE = 2'b01,
        MSG_FWD   = 2'b10,
        MSG_INV   = 2'b11
    } msg_t;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_SHARE = 3'd1,
        FS_INV   = 3'd2,
        FS_GRANT = 3'd3,
        FS_FWD   = 3'd4
    } fsm_t;
endpackage

// File: rtl/dir_store.sv
// Directory entry and line data storage, one combinational read port and
// one entry write port plus one data write port.
// Assumes: a single client; writes take effect at the next clock edge.
module dir_store
    import dir_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int NODES  = 8,
    parameter int PTRS   = 4,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LINE_W-1:0]              rd_line,
    output line_st_t                       rd_st,
    output logic                           rd_dirty,
    output logic                           rd_ovf,
    output logic [PTRS-1:0]                rd_pv,
    output logic [PTRS-1:0][NODE_W-1:0]    rd_ptr,
    output logic [DATA_W-1:0]              rd_data,
    input  logic                           we,
    input  logic [LINE_W-1:0]              wr_line,
    input  line_st_t                       wr_st,
    input  logic                           wr_dirty,
    input  logic                           wr_ovf,
    input  logic [PTRS-1:0]                wr_pv,
    input  logic [PTRS-1:0][NODE_W-1:0]    wr_ptr,
    input  logic                           dwe,
    input  logic [DATA_W-1:0]              dwr_data
);
    line_st_t                     st_q    [LINES];
    logic                         dirty_q [LINES];
    logic                         ovf_q   [LINES];
    logic [PTRS-1:0]              pv_q    [LINES];
    logic [PTRS-1:0][NODE_W-1:0]  ptr_q   [LINES];
    logic [DATA_W-1:0]            data_q  [LINES];

    // Read port: present the addressed entry and data.
    always_comb begin
        rd_st    = st_q[rd_line];
        rd_dirty = dirty_q[rd_line];
        rd_ovf   = ovf_q[rd_line];
        rd_pv    = pv_q[rd_line];
        rd_ptr   = ptr_q[rd_line];
        rd_data  = data_q[rd_line];
    end

    // Entry and data update; reset empties every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]    <= ST_UNUSED;
                dirty_q[i] <= 1'b0;
                ovf_q[i]   <= 1'b0;
                pv_q[i]    <= '0;
                ptr_q[i]   <= '0;
                data_q[i]  <= '0;
            end
        end else begin
            if (we) begin
                st_q[wr_line]    <= wr_st;
                dirty_q[wr_line] <= wr_dirty;
                ovf_q[wr_line]   <= wr_ovf;
                pv_q[wr_line]    <= wr_pv;
                ptr_q[wr_line]   <= wr_ptr;
            end
            if (dwe) begin
                data_q[wr_line] <= dwr_data;
            end
        end
    end
endmodule

// File: rtl/dir_ptr_scan.sv
// Pointer scanner: lowest set slot of a selection mask, lowest free slot of
// the valid mask, and per-slot match of a node against valid pointers.
// Assumes: PTRS >= 2.
module dir_ptr_scan #(
    parameter int PTRS   = 4,
    parameter int NODE_W = 3,
    localparam int IDX_W = $clog2(PTRS)
) (
    input  logic [PTRS-1:0]              sel_mask,
    input  logic [PTRS-1:0]              valid_mask,
    input  logic [PTRS-1:0][NODE_W-1:0]  ptrs,
    input  logic [NODE_W-1:0]            node,
    output logic [IDX_W-1:0]             low_idx,
    output logic [IDX_W-1:0]             free_idx,
    output logic                         free_any,
    output logic [PTRS-1:0]              hit_vec
);
    // Priority search from the top so the lowest index wins.
    always_comb begin
        low_idx  = '0;
        free_idx = '0;
        free_any = 1'b0;
        for (int i = PTRS - 1; i >= 0; i--) begin
            if (sel_mask[i]) low_idx = IDX_W'(i);
            if (!valid_mask[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    // One comparator per pointer slot.
    for (genvar g = 0; g < PTRS; g++) begin : g_hit
        assign hit_vec[g] = valid_mask[g] && (ptrs[g] == node);
    end
endmodule

// File: rtl/dir_ctrl.sv
// Home-node limited-pointer directory controller. Accepts one request at a
// time, emits its messages one per handshake, commits the entry update with
// the final grant, and traps to software on pointer overflow.
// Assumes: PTRS >= 2, DATA_W >= log2(NODES), one outstanding trap at a time.
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int LINES  = 16,
    parameter int PTRS   = 4,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES),
    localparam int IDX_W  = $clog2(PTRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_type,
    output logic [NODE_W-1:0] msg_dest,
    output logic [LINE_W-1:0] msg_line,
    output logic [DATA_W-1:0] msg_data,
    output logic              trap_valid,
    output logic [LINE_W-1:0] trap_line,
    output logic [NODE_W-1:0] trap_node,
    input  logic              trap_ack
);
    fsm_t                        fsm_q;
    logic [NODE_W-1:0]           cur_node_q;
    logic [LINE_W-1:0]           cur_line_q;
    line_st_t                    w_st_q;
    logic                        w_dirty_q, w_ovf_q;
    logic [PTRS-1:0]             w_pv_q, inv_q;
    logic [PTRS-1:0][NODE_W-1:0] w_ptr_q, old_ptr_q;
    logic [NODE_W-1:0]           dest_q;
    logic                        pend_trap_q;
    logic                        trap_q;
    logic [LINE_W-1:0]           trap_line_q;
    logic [NODE_W-1:0]           trap_node_q;

    line_st_t                    rd_st;
    logic                        rd_dirty, rd_ovf;
    logic [PTRS-1:0]             rd_pv;
    logic [PTRS-1:0][NODE_W-1:0] rd_ptr;
    logic [DATA_W-1:0]           rd_data;

    logic                        idle, accept, hit, free_any;
    logic [IDX_W-1:0]            low_idx, free_idx;
    logic [PTRS-1:0]             hit_vec, scan_sel;
    logic [PTRS-1:0][NODE_W-1:0] scan_ptr, ins_ptr;
    logic [PTRS-1:0]             ins_pv;

    line_st_t                    n_st;
    logic                        n_dirty, n_ovf, d_trap;
    logic [PTRS-1:0]             n_pv, d_inv;
    logic [PTRS-1:0][NODE_W-1:0] n_ptr;
    fsm_t                        d_next;
    logic                        commit, wback;

    assign idle   = (fsm_q == FS_IDLE);
    assign accept = req_valid && req_ready;
    assign wback  = accept && req_kind[1];
    assign commit = (fsm_q == FS_GRANT) && msg_ready;

    dir_store #(.LINES(LINES), .NODES(NODES), .PTRS(PTRS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_line(idle ? req_line : cur_line_q),
        .rd_st(rd_st), .rd_dirty(rd_dirty), .rd_ovf(rd_ovf),
        .rd_pv(rd_pv), .rd_ptr(rd_ptr), .rd_data(rd_data),
        .we(commit || wback),
        .wr_line(idle ? req_line : cur_line_q),
        .wr_st(idle ? n_st : w_st_q),
        .wr_dirty(idle ? n_dirty : w_dirty_q),
        .wr_ovf(idle ? n_ovf : w_ovf_q),
        .wr_pv(idle ? n_pv : w_pv_q),
        .wr_ptr(idle ? n_ptr : w_ptr_q),
        .dwe(wback), .dwr_data(req_data)
    );

    // Scanner looks at the stored entry when idle, at pending invalidates otherwise.
    assign scan_sel = idle ? rd_pv : inv_q;
    assign scan_ptr = idle ? rd_ptr : old_ptr_q;

    dir_ptr_scan #(.PTRS(PTRS), .NODE_W(NODE_W)) u_scan (
        .sel_mask(scan_sel), .valid_mask(rd_pv), .ptrs(scan_ptr), .node(req_node),
        .low_idx(low_idx), .free_idx(free_idx), .free_any(free_any), .hit_vec(hit_vec)
    );

    assign hit = |hit_vec;

    // Decide the new entry, the message sequence and any trap for the request.
    always_comb begin
        n_st    = rd_st;
        n_dirty = rd_dirty;
        n_ovf   = rd_ovf;
        n_pv    = rd_pv;
        n_ptr   = rd_ptr;
        d_next  = FS_GRANT;
        d_trap  = 1'b0;
        d_inv   = '0;
        ins_pv  = rd_pv | (PTRS'(1) << free_idx);
        ins_ptr = rd_ptr;
        ins_ptr[free_idx] = req_node;
        if (req_kind[1]) begin
            d_next  = FS_IDLE;
            n_dirty = 1'b0;
        end else if (req_kind[0]) begin
            n_st     = ST_EXCL;
            n_dirty  = 1'b1;
            n_ovf    = 1'b0;
            n_pv     = PTRS'(1);
            n_ptr[0] = req_node;
            d_inv    = rd_pv & ~hit_vec;
            d_trap   = rd_ovf;
            d_next   = (|d_inv) ? FS_INV : FS_GRANT;
        end else begin
            case (rd_st)
                ST_EXCL: begin
                    if (hit) begin
                        d_next = FS_GRANT;
                    end else if (rd_dirty) begin
                        d_next = FS_FWD;
                    end else begin
                        d_next = FS_SHARE;
                        n_st   = ST_SHARED;
                        n_pv   = ins_pv;
                        n_ptr  = ins_ptr;
                    end
                end
                ST_SHARED: begin
                    if (!hit && free_any) begin
                        n_pv  = ins_pv;
                        n_ptr = ins_ptr;
                    end else if (!hit) begin
                        n_ovf  = 1'b1;
                        d_trap = 1'b1;
                    end
                end
                default: begin
                    n_st     = ST_EXCL;
                    n_dirty  = 1'b0;
                    n_pv     = PTRS'(1);
                    n_ptr[0] = req_node;
                end
            endcase
        end
    end

    // Stall while busy, and on a pending trap for the same line or a second trap.
    assign req_ready = idle && !(trap_q && (req_line == trap_line_q || d_trap));

    // Sequencer: latch the request, then step through its messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= FS_IDLE;
            cur_node_q  <= '0;
            cur_line_q  <= '0;
            w_st_q      <= ST_UNUSED;
            w_dirty_q   <= 1'b0;
            w_ovf_q     <= 1'b0;
            w_pv_q      <= '0;
            w_ptr_q     <= '0;
            old_ptr_q   <= '0;
            inv_q       <= '0;
            dest_q      <= '0;
            pend_trap_q <= 1'b0;
        end else begin
            case (fsm_q)
                FS_IDLE: if (accept) begin
                    cur_node_q  <= req_node;
                    cur_line_q  <= req_line;
                    w_st_q      <= n_st;
                    w_dirty_q   <= n_dirty;
                    w_ovf_q     <= n_ovf;
                    w_pv_q      <= n_pv;
                    w_ptr_q     <= n_ptr;
                    old_ptr_q   <= rd_ptr;
                    inv_q       <= d_inv;
                    dest_q      <= rd_ptr[low_idx];
                    pend_trap_q <= d_trap;
                    fsm_q       <= d_next;
                end
                FS_SHARE: if (msg_ready) fsm_q <= FS_GRANT;
                FS_INV: if (msg_ready) begin
                    inv_q[low_idx] <= 1'b0;
                    if ((inv_q & ~(PTRS'(1) << low_idx)) == '0) fsm_q <= FS_GRANT;
                end
                FS_GRANT: if (msg_ready) fsm_q <= FS_IDLE;
                FS_FWD: if (msg_ready) fsm_q <= FS_IDLE;
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end

    // Trap register: raised with the committing grant, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q      <= 1'b0;
            trap_line_q <= '0;
            trap_node_q <= '0;
        end else if (commit && pend_trap_q) begin
            trap_q      <= 1'b1;
            trap_line_q <= cur_line_q;
            trap_node_q <= cur_node_q;
        end else if (trap_ack) begin
            trap_q <= 1'b0;
        end
    end

    // Outgoing message fields by sequencer state.
    always_comb begin
        msg_valid = !idle;
        msg_line  = cur_line_q;
        msg_data  = '0;
        msg_dest  = dest_q;
        msg_type  = MSG_GRANT;
        case (fsm_q)
            FS_SHARE: msg_type = MSG_SHARE;
            FS_INV: begin
                msg_type = MSG_INV;
                msg_dest = old_ptr_q[low_idx];
            end
            FS_FWD: begin
                msg_type = MSG_FWD;
                msg_data = DATA_W'(cur_node_q);
            end
            default: begin
                msg_dest = cur_node_q;
                msg_data = rd_data;
            end
        endcase
    end

    assign trap_valid = trap_q;
    assign trap_line  = trap_line_q;
    assign trap_node  = trap_node_q;
endmodule

// File: rtl/dir_ctrl_chk.sv
// Protocol checker for dir_ctrl, attached by bind.
// Assumes: sampled on the rising clock edge with synchronous reset.
module dir_ctrl_chk #(
    parameter int NODES  = 8,
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int LINE_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_type,
    input logic [NODE_W-1:0] msg_dest,
    input logic [LINE_W-1:0] msg_line,
    input logic [DATA_W-1:0] msg_data,
    input logic              trap_valid,
    input logic [LINE_W-1:0] trap_line,
    input logic              trap_ack
);
    // R1: reset leaves no message and no trap.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !msg_valid && !trap_valid);

    // R10: a stalled message keeps its fields.
    a_r10_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_dest)
                                     && $stable(msg_line) && $stable(msg_data));

    // R10: no request is taken while a message is outstanding.
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !req_ready);

    // R7: the trap holds, with its line, until acknowledged.
    a_r7_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_ack |=> trap_valid && $stable(trap_line));

    // R8: the trapped line is stalled.
    a_r8_line_stall: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && (req_line == trap_line) |-> !req_ready);
endmodule

bind dir_ctrl dir_ctrl_chk #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dir_ctrl_test.sv
`timescale 1ns/1ps
module dir_ctrl_test;
    localparam int NODES = 8, LINES = 16, PTRS = 4, DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [2:0]  req_node = '0;
    logic [3:0]  req_line = '0;
    logic [31:0] req_data = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [1:0]  msg_type;
    logic [2:0]  msg_dest;
    logic [3:0]  msg_line;
    logic [31:0] msg_data;
    logic        trap_valid;
    logic [3:0]  trap_line;
    logic [2:0]  trap_node;
    logic        trap_ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit bp_en = 1'b0;
    int cyc = 0;

    typedef struct packed {
        logic [1:0]  t;
        logic [2:0]  d;
        logic [3:0]  l;
        logic [31:0] v;
    } msg_s;
    msg_s  expq[$];
    string tagq[$];

    always #2 clk = ~clk;

    dir_ctrl #(.NODES(NODES), .LINES(LINES), .PTRS(PTRS), .DATA_W(DW)) uut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [1:0] t, input logic [2:0] d, input logic [3:0] l,
                              input logic [31:0] v, input string tag);
        expq.push_back({t, d, l, v});
        tagq.push_back(tag);
    endtask

    // Monitor: compare each accepted message with the scoreboard, then set ready.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && msg_valid && msg_ready) begin
            if (req_ready) chk(1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected message", 64'({msg_type, msg_dest, msg_line, msg_data}), 64'd0);
            end else begin
                msg_s  e;
                string tg;
                e  = expq.pop_front();
                tg = tagq.pop_front();
                chk({msg_type, msg_dest, msg_line, msg_data} == e, tg, "message",
                    64'({msg_type, msg_dest, msg_line, msg_data}), 64'(e));
            end
        end
        msg_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
    end

    task automatic send(input logic [1:0] k, input logic [2:0] n, input logic [3:0] l,
                        input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_node = n; req_line = l; req_data = d;
        #0.5;
        while (!req_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.5;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #0.5;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(msg_valid == 1'b0, "R1", "msg_valid", 64'(msg_valid), 64'd0);
        chk(trap_valid == 1'b0, "R1", "trap_valid", 64'(trap_valid), 64'd0);

        // R1/R2: fresh line reads back zero data with an exclusive grant
        expect_msg(2'b00, 3'd1, 4'd0, 32'h0, "R1");
        send(2'b00, 3'd1, 4'd0, '0);
        drain();

        // R6: write-back sends nothing; the later grant carries the stored value
        send(2'b10, 3'd0, 4'd3, 32'hA5A5_0003);
        drain();
        expect_msg(2'b00, 3'd2, 4'd3, 32'hA5A5_0003, "R2");
        send(2'b00, 3'd2, 4'd3, '0);
        drain();

        // R3: second reader of a clean exclusive line
        expect_msg(2'b01, 3'd2, 4'd3, 32'h0, "R3");
        expect_msg(2'b00, 3'd5, 4'd3, 32'hA5A5_0003, "R3");
        send(2'b00, 3'd5, 4'd3, '0);
        drain();

        // R11: repeat read by a recorded sharer
        expect_msg(2'b00, 3'd5, 4'd3, 32'hA5A5_0003, "R11");
        send(2'b00, 3'd5, 4'd3, '0);
        drain();

        // fill the remaining pointers: slots now hold 2,5,1,7
        expect_msg(2'b00, 3'd1, 4'd3, 32'hA5A5_0003, "R7");
        send(2'b00, 3'd1, 4'd3, '0);
        expect_msg(2'b00, 3'd7, 4'd3, 32'hA5A5_0003, "R7");
        send(2'b00, 3'd7, 4'd3, '0);
        drain();
        chk(trap_valid == 1'b0, "R7", "no trap before overflow", 64'(trap_valid), 64'd0);

        // R7: fifth reader overflows
        expect_msg(2'b00, 3'd4, 4'd3, 32'hA5A5_0003, "R7");
        send(2'b00, 3'd4, 4'd3, '0);
        drain();
        chk(trap_valid == 1'b1, "R7", "trap raised", 64'(trap_valid), 64'd1);
        chk(trap_line == 4'd3, "R7", "trap line", 64'(trap_line), 64'd3);
        chk(trap_node == 3'd4, "R7", "trap node", 64'(trap_node), 64'd4);

        // R8: trapped line stalls
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_node = 3'd0; req_line = 4'd3;
        for (int i = 0; i < 3; i++) begin
            #0.5;
            chk(req_ready == 1'b0, "R8", "stall on trapped line", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;

        // R8: other line still served
        expect_msg(2'b00, 3'd6, 4'd9, 32'h0, "R8");
        send(2'b00, 3'd6, 4'd9, '0);
        drain();
        chk(trap_valid == 1'b1, "R7", "trap held", 64'(trap_valid), 64'd1);

        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        #0.5;
        chk(trap_valid == 1'b0, "R7", "trap cleared by ack", 64'(trap_valid), 64'd0);

        // R5/R9/R10: write under backpressure, slot order 2,1,7 skipping writer 5
        bp_en = 1'b1;
        expect_msg(2'b11, 3'd2, 4'd3, 32'h0, "R5");
        expect_msg(2'b11, 3'd1, 4'd3, 32'h0, "R5");
        expect_msg(2'b11, 3'd7, 4'd3, 32'h0, "R5");
        expect_msg(2'b00, 3'd5, 4'd3, 32'hA5A5_0003, "R5");
        send(2'b01, 3'd5, 4'd3, '0);
        drain();
        bp_en = 1'b0;
        chk(trap_valid == 1'b1, "R9", "trap after overflowed write", 64'(trap_valid), 64'd1);
        chk(trap_line == 4'd3, "R9", "trap line", 64'(trap_line), 64'd3);
        chk(trap_node == 3'd5, "R9", "trap node", 64'(trap_node), 64'd5);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;

        // R4: dirty line read is forwarded to the owner
        expect_msg(2'b10, 3'd5, 4'd3, 32'd6, "R4");
        send(2'b00, 3'd6, 4'd3, '0);
        drain();

        // R6: write-back cleans the line; next reader gets share + grant with new data
        send(2'b10, 3'd5, 4'd3, 32'h0000_1234);
        drain();
        expect_msg(2'b01, 3'd5, 4'd3, 32'h0, "R6");
        expect_msg(2'b00, 3'd6, 4'd3, 32'h0000_1234, "R6");
        send(2'b00, 3'd6, 4'd3, '0);
        drain();
        chk(trap_valid == 1'b0, "R9", "overflow cleared by write", 64'(trap_valid), 64'd0);

        // R5: write to an unused line grants only; R4: then forwarded
        expect_msg(2'b00, 3'd4, 4'd12, 32'h0, "R5");
        send(2'b01, 3'd4, 4'd12, '0);
        drain();
        expect_msg(2'b10, 3'd4, 4'd12, 32'd1, "R4");
        send(2'b00, 3'd1, 4'd12, '0);
        drain();

        chk(expq.size() == 0, "R10", "scoreboard empty", 64'(expq.size()), 64'd0);
        finish_run();
    end
endmodule